// File: doc/BRIEF.md
# Page-Boundary Memory Decoder

This block splits a 16-bit memory map between on-board RAM and an 8K ROM window at the top of the map. The ROM window can only sit where the three top address bits are all ones (E000h to FFFFh). A five-bit page setting, standing in for a bank of switches, gives bits 12 to 8 of the boundary page inside that window. The full boundary page is therefore E0h plus the setting.

A mode bit picks one of two boundary rules. In the legacy rule, the boundary page is the first ROM page. In the extended rule, the boundary page is the last RAM page and ROM starts one page higher. This lets a setting of 1Fh in extended mode give RAM the whole 64K space.

A ROM enable input removes every ROM response without moving the RAM boundary. All inputs are captured in one register stage. The selects are decoded combinationally from those registered copies and gated by the registered memory-cycle strobe. The ROM offset is the low thirteen bits of the registered address.

Top module: `page_boundary_decoder`

## Requirements
- R1: With the strobe high, any address whose page is below E0h asserts the RAM select and not the ROM select, for every setting, mode and enable.
- R2: In legacy rule (mode = 0), with boundary page B = E0h + setting, pages below B select RAM. Pages at or above B select ROM when ROM is enabled.
- R3: In extended rule (mode = 1), pages at or below B select RAM. Pages above B select ROM when ROM is enabled.
- R4: In extended rule with setting 1Fh, every page 00h to FFh selects RAM and ROM is never selected.
- R5: In legacy rule, pages FFh never select RAM, for any setting.
- R6: With ROM enable = 0, the ROM select stays low. The RAM select is the same as with ROM enabled, so pages above the RAM region select nothing.
- R7: With the strobe low, both selects are low.
- R8: The RAM select and the ROM select are never high together.
- R9: The ROM offset equals address bits 12 to 0, so FF00h gives 1F00h. All outputs reflect the inputs present at the previous rising clock edge.
- R10: While reset is active, and before any input is captured, both selects and the offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Memory address |
| mem_strobe | input | 1 | Memory-cycle strobe, high during a memory access |
| page_setting | input | 5 | Boundary page bits 12 to 8 |
| rom_enable | input | 1 | 1 lets ROM respond |
| ext_mode | input | 1 | 0 = legacy rule, 1 = extended rule |
| ram_sel | output | 1 | RAM select |
| rom_sel | output | 1 | ROM select |
| rom_offset | output | 13 | Address inside the 8K ROM |

## Verification
The bench builds the decoder with its default widths: a 16-bit address, an 8K ROM and a five-bit setting. These widths keep the space small enough to cover completely. All 32 settings are swept across both rules, both enable states and all 256 pages, with the strobe high and the low address byte varied. The sweep therefore reaches both sides of every boundary, the full-64K case and the never-RAM top page. A further pass with the strobe low checks that both selects stay low.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int ADDR_W    = 16;
  localparam int PAGE_BITS = 8;
  localparam int ROM_AW    = 13;
  localparam int SET_W     = ROM_AW - PAGE_BITS;
  localparam int TOP_W     = ADDR_W - ROM_AW;
  localparam int HI_W      = ADDR_W - PAGE_BITS;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              strobe;
    logic [SET_W-1:0]  setting;
    logic              rom_en;
    logic              ext;
  } bus_req_t;
endpackage

// File: rtl/pbd_capture.sv
module pbd_capture
  import pbd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  bus_req_t req_d,
  output bus_req_t req_q
);
  bus_req_t req_nxt;

  always_comb begin
    req_nxt = req_q;
    if (load_en) req_nxt = req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_nxt;
  end
endmodule

// File: rtl/pbd_compare.sv
module pbd_compare
  import pbd_pkg::*;
(
  input  logic [HI_W-1:0]  page,
  input  logic [SET_W-1:0] setting,
  output logic             below,
  output logic             equal
);
  logic [HI_W-1:0] boundary;

  always_comb begin
    boundary = {{TOP_W{1'b1}}, setting};
    below    = page < boundary;
    equal    = page == boundary;
  end
endmodule

// File: rtl/page_boundary_decoder.sv
module page_boundary_decoder
  import pbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              mem_strobe,
  input  logic [4:0]        page_setting,
  input  logic              rom_enable,
  input  logic              ext_mode,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic [12:0]       rom_offset
);
  bus_req_t req_d, req_q;
  logic below, equal, ram_region;
  logic [HI_W-1:0] page_q;

  always_comb begin
    req_d.addr    = bus_addr;
    req_d.strobe  = mem_strobe;
    req_d.setting = page_setting;
    req_d.rom_en  = rom_enable;
    req_d.ext     = ext_mode;
  end

  pbd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .load_en(1'b1), .req_d(req_d), .req_q(req_q)
  );

  assign page_q = req_q.addr[ADDR_W-1 -: HI_W];

  pbd_compare u_cmp (
    .page(page_q), .setting(req_q.setting), .below(below), .equal(equal)
  );

  always_comb begin
    ram_region = below | (req_q.ext & equal);
    ram_sel    = req_q.strobe & ram_region;
    rom_sel    = req_q.strobe & req_q.rom_en & ~ram_region;
    rom_offset = req_q.addr[ROM_AW-1:0];
  end

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && rom_sel));

  assert_low_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_strobe) && $past(bus_addr[15:13]) != 3'b111) |-> ram_sel);

  assert_full_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_strobe) && $past(ext_mode) && $past(page_setting) == 5'h1f) |-> (ram_sel && !rom_sel));

  assert_top_not_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ext_mode) && $past(bus_addr[15:8]) == 8'hff) |-> !ram_sel);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mem_strobe) |-> (!ram_sel && !rom_sel));

  assert_rom_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rom_enable) |-> !rom_sel);
endmodule

// File: tb/page_boundary_decoder_tb_top.sv
module page_boundary_decoder_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic mem_strobe = 0;
  logic [4:0] page_setting = '0;
  logic rom_enable = 0;
  logic ext_mode = 0;
  logic ram_sel, rom_sel;
  logic [12:0] rom_offset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic ram;
    logic rom;
    logic [12:0] off;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  page_boundary_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_strobe(mem_strobe),
    .page_setting(page_setting), .rom_enable(rom_enable), .ext_mode(ext_mode),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .rom_offset(rom_offset)
  );

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic s, input logic [4:0] set,
                       input logic en, input logic ext);
    exp_t e;
    int first_rom;
    first_rom = 224 + int'(set) + (ext ? 1 : 0);
    e.ram = s && (int'(a[15:8]) < first_rom);
    e.rom = s && en && (int'(a[15:8]) >= first_rom);
    e.off = a[12:0];
    if (!s) e.tag = "R7";
    else if (a[15:13] != 3'b111) e.tag = "R1";
    else if (ext && set == 5'h1f) e.tag = "R4";
    else if (!ext && a[15:8] == 8'hff) e.tag = "R5";
    else if (!en) e.tag = "R6";
    else if (ext) e.tag = "R3";
    else e.tag = "R2";
    @(negedge clk);
    bus_addr = a; mem_strobe = s; page_setting = set; rom_enable = en; ext_mode = ext;
    sb.push_back(e);
  endtask

  // Monitor: outputs settle after the capturing edge
  always @(posedge clk) begin
    #2;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " R8 sel"}, {13'd0, ram_sel, rom_sel}, {13'd0, e.ram, e.rom});
      check("R9 offset", {2'd0, rom_offset}, {2'd0, e.off});
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R10 reset", {ram_sel, rom_sel, rom_offset}, 15'd0);
    bus_addr = 16'hff00; mem_strobe = 1; rom_enable = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 held", {ram_sel, rom_sel, rom_offset}, 15'd0);
    @(negedge clk);
    rst_n = 1;
    drive(16'hff00, 1, 5'h1f, 1, 0);
    for (int m = 0; m < 2; m++)
      for (int en = 0; en < 2; en++)
        for (int s = 0; s < 32; s++)
          for (int p = 0; p < 256; p++)
            drive({p[7:0], p[7:0] ^ {s[4:0], 3'(m + en)}}, 1, s[4:0], en[0], m[0]);
    for (int p = 0; p < 256; p += 5)
      drive({p[7:0], 8'h5a}, 0, p[4:0], 1, p[0]);
    drive(16'h0000, 1, 5'h00, 1, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule